// File: doc/BRIEF.md
# Collision, Heartbeat and Jabber Monitor

This block watches the MAC-side activity of one 10/100 Ethernet port. It raises a collision indication whenever the port is transmitting and receiving at once in half duplex. In 10 Mb/s half duplex with the heartbeat option on, it also emits a short signal-quality-error pulse on the same collision output a fixed time after each transmission ends. It guards the line against a transmitter that never stops: a 10 Mb/s transmission that runs too long locks the transmit path out for a fixed release period, and a sticky flag records that this happened.

All time spans are counted in ticks of a reference strobe. Each span is a parameter given in tick counts, so a scaled-down bench can use short values. With a 100 ns tick the defaults give a 1.2 us heartbeat delay, a 1.0 us pulse, an 85 ms jabber window and a 500 ms release delay. In the requirements below the parameters are named D (heartbeat delay), L (pulse length), J (jabber window) and K (release delay). An "edge" is a rising edge of `clk` with `rst_n` high.

Top module: `col_hb_jab_mon`

## Requirements
- R1: In half duplex at either speed, `col_o` is 1 in the cycle after an edge that samples `tx_en` and `rx_act` both high. It is 0 after an edge that sees only one of them, unless a heartbeat pulse is running.
- R2: When `full_dup` is 1 on two edges in a row, `col_o` is 0 after the second edge, whatever `tx_en` and `rx_act` do.
- R3: Take the first edge that samples `tx_en` low after it was high, in 10 Mb/s (`spd100`=0) half duplex with `hb_en`=1 and `tick` high every cycle. `col_o` is then high after the D-th to the (D+L-1)-th edges that follow, and low before and after that window.
- R4: No heartbeat pulse is produced when `hb_en` is 0, when `full_dup` is 1, or when `spd100` is 1. Leaving the eligible mode during a pending or running pulse cancels it.
- R5: If `tx_en` is sampled high again while the heartbeat delay is still running, that heartbeat is dropped and `col_o` stays low.
- R6: With `spd100`=0 and `tick` high every cycle, `tx_en` sampled high on J edges in a row sets `jab_act_o` after the J-th edge and not before. A single edge with `tx_en` low, or with `spd100`=1, restarts the count.
- R7: Once set, `jab_act_o` stays high for K ticks, whatever `tx_en` does. It falls after the K-th edge that has `tick` high.
- R8: `tx_inh_o` is high exactly while `jab_act_o` is high.
- R9: `jab_seen_o` is set on the edge that raises `jab_act_o`. It stays set after the release, and an edge that samples `jab_clr` high clears it.
- R10: The heartbeat and jabber timers advance only on edges that sample `tick` high. With `tick` held low, a transmission of any length never sets `jab_act_o`.
- R11: While `rst_n` is low, all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Reference strobe; timers advance on edges where it is high |
| tx_en | input | 1 | Transmit activity from the MAC |
| rx_act | input | 1 | Receive carrier activity |
| spd100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| full_dup | input | 1 | 1 = full duplex, 0 = half duplex |
| hb_en | input | 1 | Heartbeat enable |
| jab_clr | input | 1 | Clears the sticky jabber flag |
| col_o | output | 1 | Collision indication, including the heartbeat pulse |
| jab_act_o | output | 1 | Jabber lockout in force |
| jab_seen_o | output | 1 | Sticky record of a jabber event |
| tx_inh_o | output | 1 | Transmit path inhibit |

## Verification
On every cycle the assertions check four things. Collision stays low in steady full duplex. At 100 Mb/s a collision can come only from a real overlap. A lockout can start only after a 10 Mb/s transmit edge with the tick present. The sticky flag follows lockout entry and the clear input. The exact heartbeat window, the abort of a pending heartbeat, the length of the jabber window and of the release delay, and the restart of the count after a gap all depend on long runs of input history. These are shown only by the bench's directed sequences, which use scaled-down tick counts.

// File: rtl/cmon_pkg.sv
package cmon_pkg;

    typedef enum logic [1:0] {
        HB_IDLE  = 2'd0,
        HB_WAIT  = 2'd1,
        HB_PULSE = 2'd2
    } hb_state_e;

    typedef enum logic {
        JB_RUN  = 1'b0,
        JB_LOCK = 1'b1
    } jb_state_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cmon_overlap.sv
module cmon_overlap (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    input  logic rx_act,
    input  logic full_dup,
    output logic ovl_o
);

    typedef struct packed {
        logic ovl;
    } ovl_st_t;

    ovl_st_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.ovl = tx_en && rx_act && !full_dup;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ovl_o = s_q.ovl;

endmodule

// File: rtl/cmon_heartbeat.sv
module cmon_heartbeat
    import cmon_pkg::*;
#(
    parameter int DLY_TICKS = 12,
    parameter int LEN_TICKS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic tx_en,
    input  logic spd100,
    input  logic full_dup,
    input  logic hb_en,
    output logic hb_o
);

    localparam int CW = $clog2(max2(DLY_TICKS, LEN_TICKS) + 1);
    localparam logic [CW-1:0] DLY_LAST = CW'(DLY_TICKS - 1);
    localparam logic [CW-1:0] LEN_LAST = CW'(LEN_TICKS - 1);

    typedef struct packed {
        hb_state_e     st;
        logic          tx;
        logic [CW-1:0] cnt;
    } hb_st_t;

    hb_st_t s_d, s_q;
    logic   eligible;

    always_comb begin
        eligible = !spd100 && !full_dup && hb_en;
        s_d      = s_q;
        s_d.tx   = tx_en;
        case (s_q.st)
            HB_IDLE: begin
                if (s_q.tx && !tx_en && eligible) begin
                    s_d.st  = HB_WAIT;
                    s_d.cnt = '0;
                end
            end
            HB_WAIT: begin
                if (!eligible || tx_en) begin
                    s_d.st  = HB_IDLE;
                    s_d.cnt = '0;
                end else if (tick) begin
                    if (s_q.cnt == DLY_LAST) begin
                        s_d.st  = HB_PULSE;
                        s_d.cnt = '0;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
            end
            HB_PULSE: begin
                if (!eligible) begin
                    s_d.st  = HB_IDLE;
                    s_d.cnt = '0;
                end else if (tick) begin
                    if (s_q.cnt == LEN_LAST) begin
                        s_d.st  = HB_IDLE;
                        s_d.cnt = '0;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
            end
            default: begin
                s_d.st  = HB_IDLE;
                s_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: HB_IDLE, tx: 1'b0, cnt: '0};
        else        s_q <= s_d;
    end

    assign hb_o = (s_q.st == HB_PULSE);

endmodule

// File: rtl/cmon_jabber.sv
module cmon_jabber
    import cmon_pkg::*;
#(
    parameter int ON_TICKS  = 850000,
    parameter int OFF_TICKS = 5000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic tx_en,
    input  logic spd100,
    input  logic jab_clr,
    output logic act_o,
    output logic seen_o
);

    localparam int CW = $clog2(max2(ON_TICKS, OFF_TICKS) + 1);
    localparam logic [CW-1:0] ON_LAST  = CW'(ON_TICKS - 1);
    localparam logic [CW-1:0] OFF_LAST = CW'(OFF_TICKS - 1);

    typedef struct packed {
        jb_state_e     st;
        logic          seen;
        logic [CW-1:0] cnt;
    } jb_st_t;

    jb_st_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.seen = s_q.seen && !jab_clr;
        case (s_q.st)
            JB_RUN: begin
                if (tx_en && !spd100) begin
                    if (tick) begin
                        if (s_q.cnt == ON_LAST) begin
                            s_d.st   = JB_LOCK;
                            s_d.cnt  = '0;
                            s_d.seen = 1'b1;
                        end else begin
                            s_d.cnt = s_q.cnt + 1'b1;
                        end
                    end
                end else begin
                    s_d.cnt = '0;
                end
            end
            JB_LOCK: begin
                if (tick) begin
                    if (s_q.cnt == OFF_LAST) begin
                        s_d.st  = JB_RUN;
                        s_d.cnt = '0;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
            end
            default: begin
                s_d.st  = JB_RUN;
                s_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: JB_RUN, seen: 1'b0, cnt: '0};
        else        s_q <= s_d;
    end

    assign act_o  = (s_q.st == JB_LOCK);
    assign seen_o = s_q.seen;

endmodule

// File: rtl/col_hb_jab_mon.sv
module col_hb_jab_mon #(
    parameter int HB_DLY_TICKS  = 12,
    parameter int HB_LEN_TICKS  = 10,
    parameter int JAB_ON_TICKS  = 850000,
    parameter int JAB_OFF_TICKS = 5000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic tx_en,
    input  logic rx_act,
    input  logic spd100,
    input  logic full_dup,
    input  logic hb_en,
    input  logic jab_clr,
    output logic col_o,
    output logic jab_act_o,
    output logic jab_seen_o,
    output logic tx_inh_o
);

    logic ovl;
    logic hb;
    logic jab_act;
    logic jab_seen;

    cmon_overlap i_ovl (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_en    (tx_en),
        .rx_act   (rx_act),
        .full_dup (full_dup),
        .ovl_o    (ovl)
    );

    cmon_heartbeat #(
        .DLY_TICKS (HB_DLY_TICKS),
        .LEN_TICKS (HB_LEN_TICKS)
    ) i_hb (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .tx_en    (tx_en),
        .spd100   (spd100),
        .full_dup (full_dup),
        .hb_en    (hb_en),
        .hb_o     (hb)
    );

    cmon_jabber #(
        .ON_TICKS  (JAB_ON_TICKS),
        .OFF_TICKS (JAB_OFF_TICKS)
    ) i_jab (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .tx_en   (tx_en),
        .spd100  (spd100),
        .jab_clr (jab_clr),
        .act_o   (jab_act),
        .seen_o  (jab_seen)
    );

    assign col_o      = ovl || hb;
    assign jab_act_o  = jab_act;
    assign jab_seen_o = jab_seen;
    assign tx_inh_o   = jab_act;

endmodule

// File: rtl/cmon_chk.sv
module cmon_chk (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic tx_en,
    input logic rx_act,
    input logic spd100,
    input logic full_dup,
    input logic jab_clr,
    input logic col_o,
    input logic jab_act_o,
    input logic jab_seen_o,
    input logic tx_inh_o
);

    // R2
    fdx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full_dup && $past(full_dup)) |-> !col_o);

    // R4
    fast_no_hb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_o && $past(spd100)) |-> $past(tx_en && rx_act && !full_dup));

    // R6
    jab_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(jab_act_o) |-> ($past(tx_en) && !$past(spd100) && $past(tick)));

    // R9
    seen_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(jab_act_o) |-> jab_seen_o);

    // R9
    seen_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(jab_clr) && !$rose(jab_act_o)) |-> !jab_seen_o);

    // R7
    release_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(jab_act_o) |-> $past(tick));

    // R8
    inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_inh_o == jab_act_o);

endmodule

bind col_hb_jab_mon cmon_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .tx_en      (tx_en),
    .rx_act     (rx_act),
    .spd100     (spd100),
    .full_dup   (full_dup),
    .jab_clr    (jab_clr),
    .col_o      (col_o),
    .jab_act_o  (jab_act_o),
    .jab_seen_o (jab_seen_o),
    .tx_inh_o   (tx_inh_o)
);

// File: tb/test_col_hb_jab_mon.sv
module test_col_hb_jab_mon;

    localparam int D = 3;
    localparam int L = 4;
    localparam int J = 20;
    localparam int K = 30;

    logic clk = 1'b0;
    logic rst_n, tick, tx_en, rx_act, spd100, full_dup, hb_en, jab_clr;
    logic col_o, jab_act_o, jab_seen_o, tx_inh_o;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    col_hb_jab_mon #(
        .HB_DLY_TICKS  (D),
        .HB_LEN_TICKS  (L),
        .JAB_ON_TICKS  (J),
        .JAB_OFF_TICKS (K)
    ) i_col_hb_jab_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .tx_en      (tx_en),
        .rx_act     (rx_act),
        .spd100     (spd100),
        .full_dup   (full_dup),
        .hb_en      (hb_en),
        .jab_clr    (jab_clr),
        .col_o      (col_o),
        .jab_act_o  (jab_act_o),
        .jab_seen_o (jab_seen_o),
        .tx_inh_o   (tx_inh_o)
    );

    typedef struct packed {
        logic tx;
        logic rx;
        logic s100;
        logic fdx;
        logic exp_col;
    } vec_t;

    localparam vec_t VEC [10] = '{
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
        '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
        '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0}
    };

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    // Transmit three cycles, drop tx_en, then watch col_o edge by edge.
    task automatic hb_run(input string req, input logic s100, input logic fdx,
                          input logic hben, input logic abort_it, input logic pulse);
        spd100   = s100;
        full_dup = fdx;
        hb_en    = hben;
        rx_act   = 1'b0;
        tx_en    = 1'b1;
        steps(3);
        tx_en = 1'b0;
        for (int j = 0; j <= 8; j++) begin
            step();
            chk(req, col_o, pulse && !abort_it && (j >= D) && (j <= D + L - 1));
            if (abort_it && j == 1) tx_en = 1'b1;
        end
        tx_en = 1'b0;
        steps(12);
    endtask

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; tick = 1'b1; tx_en = 1'b0; rx_act = 1'b0;
        spd100 = 1'b0; full_dup = 1'b0; hb_en = 1'b0; jab_clr = 1'b0;
        steps(3);
        // R11 reset state
        chk("R11 col", col_o, 1'b0);
        chk("R11 jab_act", jab_act_o, 1'b0);
        chk("R11 jab_seen", jab_seen_o, 1'b0);
        chk("R11 tx_inh", tx_inh_o, 1'b0);
        rst_n = 1'b1;
        steps(2);

        // R1 / R2 vector walk
        for (int i = 0; i < 10; i++) begin
            tx_en    = VEC[i].tx;
            rx_act   = VEC[i].rx;
            spd100   = VEC[i].s100;
            full_dup = VEC[i].fdx;
            step();
            chk(VEC[i].fdx ? "R2 vector" : "R1 vector", col_o, VEC[i].exp_col);
        end
        tx_en = 1'b0; rx_act = 1'b0; full_dup = 1'b0; spd100 = 1'b0;
        steps(4);

        // R3 heartbeat window
        hb_run("R3 heartbeat", 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        // R4 suppressed cases
        hb_run("R4 hb_en off", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        hb_run("R4 full duplex", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        hb_run("R4 100Mb", 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        // R5 abort
        hb_run("R5 abort", 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);

        // R6 / R7 / R8 / R9 jabber
        spd100 = 1'b0; full_dup = 1'b0; hb_en = 1'b0; rx_act = 1'b0;
        tx_en = 1'b1;
        steps(J - 1);
        chk("R6 before window", jab_act_o, 1'b0);
        step();
        chk("R6 entry", jab_act_o, 1'b1);
        chk("R8 inhibit on", tx_inh_o, 1'b1);
        chk("R9 seen set", jab_seen_o, 1'b1);
        tx_en = 1'b0;
        steps(K - 1);
        chk("R7 still locked", jab_act_o, 1'b1);
        step();
        chk("R7 released", jab_act_o, 1'b0);
        chk("R8 inhibit off", tx_inh_o, 1'b0);
        chk("R9 seen held", jab_seen_o, 1'b1);
        jab_clr = 1'b1;
        step();
        jab_clr = 1'b0;
        chk("R9 seen cleared", jab_seen_o, 1'b0);

        // R6 gap restarts count
        tx_en = 1'b1;
        steps(J - 5);
        tx_en = 1'b0;
        step();
        tx_en = 1'b1;
        steps(J - 5);
        chk("R6 gap restart", jab_act_o, 1'b0);
        tx_en = 1'b0;
        steps(3);

        // R6 no jabber at 100 Mb/s
        spd100 = 1'b1;
        tx_en  = 1'b1;
        steps(2 * J);
        chk("R6 100Mb", jab_act_o, 1'b0);
        tx_en = 1'b0;
        steps(3);
        spd100 = 1'b0;

        // R10 tick held low
        tick  = 1'b0;
        tx_en = 1'b1;
        steps(2 * J);
        chk("R10 no tick", jab_act_o, 1'b0);
        tx_en = 1'b0;
        steps(2);
        tick = 1'b1;
        steps(2);
        chk("R10 seen untouched", jab_seen_o, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule